// File: doc/BRIEF.md
# ADC Sequence Status Flag Controller

This block holds the status flags of an analog-to-digital converter that runs a sequence of one to eight conversions. The flags are a sequence-complete flag, one conversion-complete flag per result slot, a trigger-overrun flag, a FIFO-overrun flag and an interrupt flag. The analog converter itself sits outside the block. It reads `seq_busy` and `cur_slot` to learn which slot to fill, and it pulses `conv_done` once per finished conversion. The block does not store any result. A result read is seen only as a strobe on `res_rd` together with a slot number.

Software reaches the block through a small register bus. Writes take effect on the clock edge. Reads are combinational on `rd_addr`.

There are three control registers:
- Address 0, interrupt and clear options: bit 0 interrupt enable, bit 1 fast clear.
- Address 1, trigger setup: bit 0 trigger enable, bit 1 level mode (0 = edge mode), bit 2 polarity (1 = rising edge or high level is active).
- Address 2, sequence length minus one, in bits [SLOT_W-1:0].

The other addresses are:
- Address 3: a write to it starts a sequence. The data is ignored.
- Address 4, status: bit 0 sequence complete, bit 1 trigger overrun, bit 2 FIFO overrun, bit 3 interrupt, bit 4 busy. Bits 0 to 2 are write-one-to-clear.
- Address 5: the conversion-complete flags, read only.

An external trigger can start a sequence when one is enabled. It passes through a `SYNC_STAGES`-deep synchronizer first.

Top module: `adc_seq_flags`

## Requirements
- R1: After reset every flag is 0, `seq_busy` is 0, `cur_slot` is 0 and `irq` is 0. All control registers read 0, which means a sequence length of 1.
- R2: A write to address 3 sets busy and `cur_slot` to 0. On the same edge it clears the sequence-complete flag, all conversion-complete flags, the interrupt flag and the FIFO-overrun flag.
- R3: While busy, each `conv_done` pulse sets the conversion-complete flag of `cur_slot` and advances the slot. The pulse for slot (address 2 value) ends the sequence: busy drops and the sequence-complete flag sets. `conv_done` while idle has no effect.
- R4: When a sequence completes with interrupt enable 1, the interrupt flag sets and drives `irq`. The interrupt flag clears whenever the sequence-complete flag is cleared.
- R5: Writing 1 to status bit 0, 1 or 2 clears the sequence-complete, trigger-overrun or FIFO-overrun flag respectively. Writing 0 to a bit leaves that flag unchanged.
- R6: The trigger-overrun flag sets only on an active trigger edge, as chosen by the polarity bit, that arrives while busy with the trigger enabled. An edge of the inactive polarity never sets it.
- R7: In edge mode, an active trigger edge while idle starts a sequence. Any trigger start clears the FIFO-overrun flag but keeps the conversion-complete flags.
- R8: A write to address 0, 1 or 2 aborts a running sequence and clears the trigger-overrun flag. It leaves the sequence-complete and conversion-complete flags as they were.
- R9: With fast clear (address 0 bit 1) set, a `res_rd` strobe clears the sequence-complete flag, the interrupt flag and the conversion-complete flag of `res_slot`. With fast clear at 0, the strobe changes nothing.
- R10: A conversion that completes into a slot whose conversion-complete flag is already 1 sets the FIFO-overrun flag.
- R11: A start write in the same cycle as the final `conv_done` of a sequence wins. After that edge the sequence-complete, interrupt and conversion-complete flags are all 0, and a new sequence is busy at slot 0.
- R12: In level mode, an active trigger level while idle starts a sequence. An inactive level starts nothing.
- R13: Addresses 0 to 2 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| res_rd | input | 1 | Result-register read strobe |
| res_slot | input | SLOT_W | Slot of the result being read |
| trig_in | input | 1 | External trigger, asynchronous |
| conv_done | input | 1 | One-cycle pulse per finished conversion |
| seq_busy | output | 1 | A sequence is running |
| cur_slot | output | SLOT_W | Slot the converter fills next |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest case to reach is the tie in R11: a start write landing on exactly the edge where the final conversion of a sequence completes. The bench reaches it by setting a one-conversion sequence and then, on a single falling edge, driving the start write and the `conv_done` pulse together. It then checks that no completion evidence survives.

The FIFO overrun is the second hard case, because a register start clears every conversion-complete flag. The bench therefore builds the overrun from trigger-started sequences. These leave the conversion-complete flags standing, so the next completion lands on a slot that is already marked.

// File: rtl/adc_seq_flags_pkg.sv
package adc_seq_flags_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      A_OPT      = 3'd0,
      A_TRIG     = 3'd1,
      A_LEN      = 3'd2,
      A_START    = 3'd3,
      A_STATUS   = 3'd4,
      A_DONE_MAP = 3'd5
   } reg_addr_e;

   // status bit positions
   localparam int ST_SEQ  = 0;
   localparam int ST_TOVR = 1;
   localparam int ST_FOVR = 2;
   localparam int ST_IRQ  = 3;
   localparam int ST_BUSY = 4;
   localparam int ST_BITS = 5;

   typedef struct packed {
      logic fast_clr;
      logic irq_en;
   } opt_t;

   typedef struct packed {
      logic pol_hi;
      logic level_mode;
      logic enable;
   } trig_cfg_t;

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic pol_hi,
   output logic act_edge,
   output logic act_level
);

   logic synced;
   logic act_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = trig_in;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1 <= 1'b0;
            else        s1 <= trig_in;
         end
         assign synced = s1;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-2:0], trig_in};
         end
         assign synced = sh[SYNC_STAGES-1];
      end
   endgenerate

   assign act_level = pol_hi ? synced : ~synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act_level;
   end

   assign act_edge = act_level & ~act_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int MAX_SLOTS = 8,
   parameter int SLOT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              conv_done,
   input  logic [SLOT_W-1:0] last_idx,
   output logic              busy,
   output logic [SLOT_W-1:0] slot,
   output logic              done_acc,
   output logic              seq_end
);

   assign done_acc = conv_done & busy & ~start & ~abort;
   assign seq_end  = done_acc & (slot == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (start) begin
         busy <= 1'b1;
         slot <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (seq_end) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (done_acc) begin
         slot <= slot + 1'b1;
      end
   end

endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
   parameter int MAX_SLOTS = 8,
   parameter int SLOT_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_start,
   input  logic                 trig_start,
   input  logic                 abort,
   input  logic                 done_acc,
   input  logic                 seq_end,
   input  logic [SLOT_W-1:0]    done_slot,
   input  logic                 irq_en,
   input  logic                 ovr_edge,
   input  logic                 w1c_seq,
   input  logic                 w1c_tovr,
   input  logic                 w1c_fovr,
   input  logic                 res_clr,
   input  logic [SLOT_W-1:0]    res_slot,
   output logic                 seq_done,
   output logic [MAX_SLOTS-1:0] ccf,
   output logic                 trig_ovr,
   output logic                 fifo_ovr,
   output logic                 irq_flag
);

   logic seq_clr;
   logic slot_hit;

   assign seq_clr  = w1c_seq | res_clr;
   assign slot_hit = done_acc & ccf[done_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seq_done <= 1'b0;
      else if (reg_start)  seq_done <= 1'b0;
      else if (seq_end)    seq_done <= 1'b1;
      else if (seq_clr)    seq_done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  irq_flag <= 1'b0;
      else if (reg_start)          irq_flag <= 1'b0;
      else if (seq_end && irq_en)  irq_flag <= 1'b1;
      else if (seq_clr)            irq_flag <= 1'b0;
   end

   genvar i;
   generate
      for (i = 0; i < MAX_SLOTS; i++) begin : g_ccf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ccf[i] <= 1'b0;
            else if (reg_start)
               ccf[i] <= 1'b0;
            else if (done_acc && (int'(done_slot) == i))
               ccf[i] <= 1'b1;
            else if (res_clr && (int'(res_slot) == i))
               ccf[i] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       fifo_ovr <= 1'b0;
      else if (reg_start || trig_start) fifo_ovr <= 1'b0;
      else if (slot_hit)                fifo_ovr <= 1'b1;
      else if (w1c_fovr)                fifo_ovr <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         trig_ovr <= 1'b0;
      else if (abort)     trig_ovr <= 1'b0;
      else if (ovr_edge)  trig_ovr <= 1'b1;
      else if (w1c_tovr)  trig_ovr <= 1'b0;
   end

endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags
   import adc_seq_flags_pkg::*;
#(
   parameter int MAX_SLOTS   = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SLOT_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              res_rd,
   input  logic [SLOT_W-1:0] res_slot,
   input  logic              trig_in,
   input  logic              conv_done,
   output logic              seq_busy,
   output logic [SLOT_W-1:0] cur_slot,
   output logic              irq
);

   generate
      if (MAX_SLOTS < 1 || MAX_SLOTS > DATA_W) begin : g_bad_slots
         $error("MAX_SLOTS must lie in 1..DATA_W");
      end
      if (DATA_W < ST_BITS || DATA_W < SLOT_W) begin : g_bad_width
         $error("DATA_W too narrow for status or length field");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   opt_t              opt_q;
   trig_cfg_t         trig_q;
   logic [SLOT_W-1:0] len_q;
   logic [SLOT_W-1:0] last_idx;

   logic wr_opt, wr_trig, wr_len, ctl_wr, reg_start, wr_stat;
   logic act_edge, act_level, trig_start, ovr_edge;
   logic done_acc, seq_end;
   logic seq_done, trig_ovr, fifo_ovr, irq_flag;
   logic [MAX_SLOTS-1:0] ccf;

   assign wr_opt    = wr_en && (wr_addr == A_OPT);
   assign wr_trig   = wr_en && (wr_addr == A_TRIG);
   assign wr_len    = wr_en && (wr_addr == A_LEN);
   assign reg_start = wr_en && (wr_addr == A_START);
   assign wr_stat   = wr_en && (wr_addr == A_STATUS);
   assign ctl_wr    = wr_opt | wr_trig | wr_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q  <= '0;
         trig_q <= '0;
         len_q  <= '0;
      end else begin
         if (wr_opt)  opt_q  <= opt_t'(wr_data[$bits(opt_t)-1:0]);
         if (wr_trig) trig_q <= trig_cfg_t'(wr_data[$bits(trig_cfg_t)-1:0]);
         if (wr_len)  len_q  <= wr_data[SLOT_W-1:0];
      end
   end

   assign last_idx = (int'(len_q) >= MAX_SLOTS) ? SLOT_W'(MAX_SLOTS - 1) : len_q;

   adc_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_in   (trig_in),
      .pol_hi    (trig_q.pol_hi),
      .act_edge  (act_edge),
      .act_level (act_level)
   );

   assign ovr_edge   = trig_q.enable & act_edge & seq_busy;
   assign trig_start = trig_q.enable & ~seq_busy & ~ctl_wr & ~reg_start &
                       (trig_q.level_mode ? act_level : act_edge);

   adc_seq_ctrl #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (reg_start | trig_start),
      .abort     (ctl_wr),
      .conv_done (conv_done),
      .last_idx  (last_idx),
      .busy      (seq_busy),
      .slot      (cur_slot),
      .done_acc  (done_acc),
      .seq_end   (seq_end)
   );

   adc_flag_bank #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_start  (reg_start),
      .trig_start (trig_start),
      .abort      (ctl_wr),
      .done_acc   (done_acc),
      .seq_end    (seq_end),
      .done_slot  (cur_slot),
      .irq_en     (opt_q.irq_en),
      .ovr_edge   (ovr_edge),
      .w1c_seq    (wr_stat & wr_data[ST_SEQ]),
      .w1c_tovr   (wr_stat & wr_data[ST_TOVR]),
      .w1c_fovr   (wr_stat & wr_data[ST_FOVR]),
      .res_clr    (res_rd & opt_q.fast_clr),
      .res_slot   (res_slot),
      .seq_done   (seq_done),
      .ccf        (ccf),
      .trig_ovr   (trig_ovr),
      .fifo_ovr   (fifo_ovr),
      .irq_flag   (irq_flag)
   );

   assign irq = irq_flag;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_OPT:      rd_data[$bits(opt_t)-1:0]      = opt_q;
         A_TRIG:     rd_data[$bits(trig_cfg_t)-1:0] = trig_q;
         A_LEN:      rd_data[SLOT_W-1:0]            = len_q;
         A_STATUS: begin
            rd_data[ST_SEQ]  = seq_done;
            rd_data[ST_TOVR] = trig_ovr;
            rd_data[ST_FOVR] = fifo_ovr;
            rd_data[ST_IRQ]  = irq_flag;
            rd_data[ST_BUSY] = seq_busy;
         end
         A_DONE_MAP: rd_data[MAX_SLOTS-1:0] = ccf;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/adc_seq_flags_chk.sv
module adc_seq_flags_chk #(
   parameter int MAX_SLOTS = 8,
   parameter int SLOT_W    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_start,
   input logic                 ctl_wr,
   input logic                 seq_end,
   input logic                 busy,
   input logic [SLOT_W-1:0]    slot,
   input logic                 seq_done,
   input logic [MAX_SLOTS-1:0] ccf,
   input logic                 trig_ovr,
   input logic                 irq
);

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_start |=> (busy && slot == '0 && ccf == '0 && !seq_done && !irq));

   // R3
   end_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end |=> (seq_done && !busy));

   // R4
   irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> seq_done);

   // R6
   ovr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_ovr) |-> $past(busy));

   // R8
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (!trig_ovr && !busy));

   // R8
   abort_keeps_ccf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (ccf == $past(ccf)));

endmodule

bind adc_seq_flags adc_seq_flags_chk #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_start (reg_start),
   .ctl_wr    (ctl_wr),
   .seq_end   (seq_end),
   .busy      (seq_busy),
   .slot      (cur_slot),
   .seq_done  (seq_done),
   .ccf       (ccf),
   .trig_ovr  (trig_ovr),
   .irq       (irq)
);

// File: tb/adc_seq_flags_test.sv
`timescale 1ns/1ps
module adc_seq_flags_test;

   localparam int SW = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       res_rd = 1'b0;
   logic [SW-1:0] res_slot = '0;
   logic       trig_in = 1'b0;
   logic       conv_done = 1'b0;
   logic       seq_busy;
   logic [SW-1:0] cur_slot;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   always #2 clk = ~clk;

   adc_seq_flags uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .res_rd(res_rd), .res_slot(res_slot), .trig_in(trig_in),
      .conv_done(conv_done), .seq_busy(seq_busy), .cur_slot(cur_slot),
      .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic read_result(input logic [SW-1:0] s);
      @(negedge clk);
      res_rd = 1'b1; res_slot = s;
      @(negedge clk);
      res_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rdreg(3'd4, d); check("R1 status", d, 8'h00);
      rdreg(3'd5, d); check("R1 done map", d, 8'h00);
      rdreg(3'd2, d); check("R1 length reg", d, 8'h00);
      check("R1 busy", seq_busy, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_basic();
      logic [7:0] d;
      wr(3'd2, 8'd2);
      wr(3'd0, 8'h01);
      wr(3'd3, 8'h00);
      check("R2 busy after start", seq_busy, 1);
      check("R2 slot after start", cur_slot, 0);
      pulse_done();
      check("R3 slot advance", cur_slot, 1);
      rdreg(3'd5, d); check("R3 first flag", d, 8'h01);
      pulse_done();
      pulse_done();
      check("R3 busy drops", seq_busy, 0);
      rdreg(3'd4, d); check("R3 R4 status after end", d, 8'h09);
      rdreg(3'd5, d); check("R3 all flags", d, 8'h07);
      check("R4 irq out", irq, 1);
      pulse_done();
      rdreg(3'd5, d); check("R3 done while idle ignored", d, 8'h07);
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      wr(3'd4, 8'h00);
      rdreg(3'd4, d); check("R5 write zero no effect", d, 8'h09);
      wr(3'd4, 8'h01);
      rdreg(3'd4, d); check("R5 R4 clear done and irq", d, 8'h00);
      check("R4 irq low", irq, 0);
   endtask

   task automatic t_abort();
      logic [7:0] d;
      wr(3'd3, 8'h00);
      rdreg(3'd5, d); check("R2 start clears map", d, 8'h00);
      pulse_done();
      wr(3'd2, 8'd2);
      check("R8 abort busy", seq_busy, 0);
      rdreg(3'd5, d); check("R8 abort keeps map", d, 8'h01);
   endtask

   task automatic t_tie();
      logic [7:0] d;
      wr(3'd2, 8'd0);
      wr(3'd3, 8'h00);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h00; conv_done = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; conv_done = 1'b0;
      rdreg(3'd4, d); check("R11 tie status", d, 8'h10);
      rdreg(3'd5, d); check("R11 tie map", d, 8'h00);
      check("R11 tie irq", irq, 0);
      check("R11 tie slot", cur_slot, 0);
      pulse_done();
      rdreg(3'd4, d); check("R11 restarted seq completes", d, 8'h09);
   endtask

   task automatic t_fast();
      logic [7:0] d;
      wr(3'd0, 8'h03);
      wr(3'd2, 8'd1);
      wr(3'd3, 8'h00);
      pulse_done(); pulse_done();
      rdreg(3'd4, d); check("R9 setup status", d, 8'h09);
      read_result(3'd1);
      rdreg(3'd5, d); check("R9 fast clears slot flag", d, 8'h01);
      rdreg(3'd4, d); check("R9 fast clears done", d, 8'h00);
      check("R9 irq cleared", irq, 0);
      wr(3'd0, 8'h01);
      rdreg(3'd0, d); check("R13 option readback", d, 8'h01);
      wr(3'd3, 8'h00);
      pulse_done(); pulse_done();
      read_result(3'd0);
      rdreg(3'd5, d); check("R9 no fast map kept", d, 8'h03);
      rdreg(3'd4, d); check("R9 no fast status kept", d, 8'h09);
   endtask

   task automatic t_trig_edge();
      logic [7:0] d;
      wr(3'd4, 8'h07);
      wr(3'd1, 8'h05);
      trig_in = 1'b1; idle(4);
      check("R7 edge starts", seq_busy, 1);
      trig_in = 1'b0; idle(4);
      rdreg(3'd4, d); check("R6 inactive edge", d[1], 0);
      trig_in = 1'b1; idle(4);
      rdreg(3'd4, d); check("R6 active edge while busy", d[1], 1);
      wr(3'd4, 8'h02);
      rdreg(3'd4, d); check("R5 clear trig ovr", d[1], 0);
      trig_in = 1'b0; idle(4);
      trig_in = 1'b1; idle(4);
      rdreg(3'd4, d); check("R6 set again", d[1], 1);
      wr(3'd2, 8'd1);
      rdreg(3'd4, d); check("R8 abort clears ovr", d[1], 0);
      check("R8 abort stops seq", seq_busy, 0);
   endtask

   task automatic t_fifo();
      logic [7:0] d;
      trig_in = 1'b0; idle(4);
      wr(3'd2, 8'd0);
      wr(3'd3, 8'h00);
      pulse_done();
      trig_in = 1'b1; idle(4);
      check("R7 trig restart", seq_busy, 1);
      rdreg(3'd5, d); check("R7 trig keeps map", d, 8'h01);
      pulse_done();
      rdreg(3'd4, d); check("R10 overrun set", d[2], 1);
      trig_in = 1'b0; idle(4);
      trig_in = 1'b1; idle(4);
      rdreg(3'd4, d); check("R7 trig start clears overrun", d[2], 0);
      pulse_done();
      rdreg(3'd4, d); check("R10 overrun again", d[2], 1);
      wr(3'd4, 8'h04);
      rdreg(3'd4, d); check("R5 clear overrun", d[2], 0);
   endtask

   task automatic t_level();
      logic [7:0] d;
      wr(3'd1, 8'h03);
      idle(4);
      check("R12 inactive level", seq_busy, 0);
      rdreg(3'd1, d); check("R13 trig readback", d, 8'h03);
      trig_in = 1'b0; idle(4);
      check("R12 active level starts", seq_busy, 1);
      pulse_done();
      idle(2);
      check("R12 level restarts", seq_busy, 1);
      trig_in = 1'b1;
      wr(3'd1, 8'h00);
      idle(4);
      check("R12 disabled idle", seq_busy, 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_basic();
      t_w1c();
      t_abort();
      t_tie();
      t_fast();
      t_trig_edge();
      t_fifo();
      t_level();
      if (!ended) begin
         ended = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!ended) begin
         ended = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule